// File: doc/BRIEF.md
# Three-Level Serial Word Receiver with Label-Bit Filter

This block recovers 32-bit words from a return-to-zero serial line with three valid levels. The line reaches the block as two comparator outputs, one for the high level and one for the low level. Both low means the idle level between bits, and both high is an illegal level. An internal sample tick is taken from the master clock, divided by one of two ratios. Each bit cell spans ten sample ticks. A mark is a run of high or low samples in the first half of the cell. The return to idle that follows the run turns the mark into a bit.

The first bit received becomes bit 1 of the word. After the 32nd bit the word can be checked against two programmed match bits for word bits 9 and 10. A word that passes is copied to a single holding register and a ready flag is raised. The host reads the word as two 16-bit halves and clears the flag by reading the second half. An illegal level, a malformed mark or an over-long idle period mid-word throws away the word in progress. A loopback mode takes the local transmitter's line outputs in place of the external line.

Top module: `a429_rx`

## Requirements
- R1: Bits are stored in arrival order. The first bit received is word bit 1, and the 32nd bit completes the word.
- R2: A bit is recovered when the line holds high or low for at least 3 consecutive sample ticks and then returns to idle. The level of that run gives the bit value: high is 1 and low is 0. Line coding on `line_one`/`line_zero` is {1,0}=high, {0,1}=low, {0,0}=idle and {1,1}=illegal.
- R3: The sample tick is the master clock divided by 10 when `rate_sel`=0 and by 80 when `rate_sel`=1. A word timed for the /10 rate is not accepted while `rate_sel`=1.
- R4: An illegal level during a word discards that word. Bits are then ignored until an idle period longer than one bit time. A well-formed word after that idle period is accepted.
- R5: When the line stays idle for more than 10 sample ticks in mid-word, the partial word is discarded and the bit count restarts at bit 1.
- R6: With `flt_en`=1, a word is accepted only when word bit 9 equals `flt_bits[0]` and word bit 10 equals `flt_bits[1]`. A rejected word leaves `ready` and the held data unchanged.
- R7: With `flt_en`=0, bits 9 and 10 have no effect on acceptance.
- R8: With `half_sel`=0, `data_out[15:11]` carries word bits 13,12,11,10,9. `data_out[10:8]` carries bits 31,30,32. `data_out[7:0]` carries bits 1..8, with bit 1 at position 7. With `half_sel`=1, `data_out[15:0]` carries word bits 29 down to 14.
- R9: `ready` rises one cycle after a word is accepted. It falls after a cycle with `rd_en`=1 and `half_sel`=1. A read with `half_sel`=0 leaves it set.
- R10: A word accepted while `ready` is still set replaces the held word.
- R11: With `test_en`=1, the block receives from `tx_one`/`tx_zero` (same coding as R2), and the external line has no effect.
- R12: After reset, `ready`=0 and both halves of `data_out` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 1 | Sample tick divider: 0 = /10, 1 = /80 |
| line_one | input | 1 | External line high-level comparator |
| line_zero | input | 1 | External line low-level comparator |
| test_en | input | 1 | Loopback from the local transmitter |
| tx_one | input | 1 | Transmitter high-level output (loopback source) |
| tx_zero | input | 1 | Transmitter low-level output (loopback source) |
| flt_en | input | 1 | Enable the bit 9/10 match filter |
| flt_bits | input | 2 | Match values: [0] for bit 9, [1] for bit 10 |
| half_sel | input | 1 | Half-word selector for `data_out` |
| rd_en | input | 1 | Read strobe; clears `ready` when `half_sel`=1 |
| ready | output | 1 | Held word is valid and unread |
| data_out | output | 16 | Selected half of the held word |

## Verification
Some properties are checked on every cycle. Sample ticks are never adjacent. A bit event appears only just after a tick, and a bit is never reported together with an abort. `ready` follows acceptance and the second-half read as specified. The held word stays still unless a word is accepted. An accepted word under an enabled filter carries the programmed bits 9 and 10. Other behaviour shows only in the bench's scenarios: the half-word bit mapping, the discard after an illegal level or a long idle, rejection of a word at the wrong rate, overwrite of an unread word, and loopback with the external line held illegal.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;

    localparam int WORD_W = 32;
    localparam int HALF_W = 16;

    typedef enum logic [1:0] {
        LV_IDLE = 2'b00,
        LV_LOW  = 2'b01,
        LV_HIGH = 2'b10,
        LV_BAD  = 2'b11
    } lvl_e;

    typedef struct packed {
        logic valid;
        logic value;
        logic abort;
        logic gap;
    } bit_evt_t;

    function automatic lvl_e decode_level(input logic hi, input logic lo);
        return lvl_e'({hi, lo});
    endfunction

    // First half: bits 13..9, 31, 30, 32, then bits 1..8 with bit 1 highest
    function automatic logic [HALF_W-1:0] pack_first(input logic [WORD_W-1:0] w);
        logic [HALF_W-1:0] r;
        r[15:11] = w[12:8];
        r[10]    = w[30];
        r[9]     = w[29];
        r[8]     = w[31];
        for (int k = 0; k < 8; k++) begin
            r[7-k] = w[k];
        end
        return r;
    endfunction

    function automatic logic [HALF_W-1:0] pack_second(input logic [WORD_W-1:0] w);
        return w[28:13];
    endfunction

endpackage

// File: rtl/a429_rx_tick.sv
module a429_rx_tick #(
    parameter int DIV_FAST = 10,
    parameter int DIV_SLOW = 80
) (
    input  logic clk,
    input  logic rst,
    input  logic rate_sel,
    output logic tick
);
    localparam int CNT_W = $clog2(DIV_SLOW);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit = rate_sel ? CNT_W'(DIV_SLOW - 1) : CNT_W'(DIV_FAST - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= limit) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R3

endmodule

// File: rtl/a429_rx_bit.sv
module a429_rx_bit
    import a429_rx_pkg::*;
#(
    parameter int SPB = 10
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  lvl_e     lvl,
    output bit_evt_t evt
);
    localparam int HALF    = SPB / 2;
    localparam int MIN_RUN = HALF / 2 + 1;
    localparam int CW      = $clog2(SPB + 2);

    logic [CW-1:0] run_cnt;
    logic [CW-1:0] null_cnt;
    logic          run_val;
    logic          spoiled;
    logic          mark_val;

    always_comb begin
        mark_val = (lvl == LV_HIGH);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt  <= '0;
            null_cnt <= '0;
            run_val  <= 1'b0;
            spoiled  <= 1'b0;
            evt      <= '0;
        end else begin
            evt <= '0;
            if (tick) begin
                case (lvl)
                    LV_BAD: begin
                        evt.abort <= 1'b1;
                        run_cnt   <= '0;
                        null_cnt  <= '0;
                        spoiled   <= 1'b0;
                    end
                    LV_HIGH, LV_LOW: begin
                        null_cnt <= '0;
                        if (run_cnt != '0 && run_val != mark_val) begin
                            evt.abort <= 1'b1;
                            run_cnt   <= CW'(1);
                            run_val   <= mark_val;
                            spoiled   <= 1'b0;
                        end else if (run_cnt == CW'(SPB)) begin
                            if (!spoiled) evt.abort <= 1'b1;
                            spoiled <= 1'b1;
                        end else begin
                            run_cnt <= run_cnt + 1'b1;
                            run_val <= mark_val;
                        end
                    end
                    default: begin
                        if (run_cnt != '0) begin
                            run_cnt  <= '0;
                            spoiled  <= 1'b0;
                            null_cnt <= CW'(1);
                            if (!spoiled) begin
                                if (run_cnt >= CW'(MIN_RUN)) begin
                                    evt.valid <= 1'b1;
                                    evt.value <= run_val;
                                end else begin
                                    evt.abort <= 1'b1;
                                end
                            end
                        end else if (null_cnt <= CW'(SPB)) begin
                            null_cnt <= null_cnt + 1'b1;
                            if (null_cnt == CW'(SPB)) evt.gap <= 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    AST_BIT_XOR_ABORT: assert property (@(posedge clk) disable iff (rst)
        !(evt.valid && evt.abort)); // R2
    AST_EVT_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        (evt.valid || evt.abort || evt.gap) |-> $past(tick)); // R3

endmodule

// File: rtl/a429_rx_frame.sv
module a429_rx_frame
    import a429_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bit_evt_t          evt,
    input  logic              flt_en,
    input  logic [1:0]        flt_bits,
    input  logic              rd_en,
    input  logic              half_sel,
    output logic              ready,
    output logic [WORD_W-1:0] hold
);
    localparam int CNT_W = $clog2(WORD_W);

    logic [WORD_W-2:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic              waiting;
    logic [WORD_W-1:0] full;
    logic              last_bit;
    logic              match;
    logic              accept;

    always_comb begin
        full     = {evt.value, shreg};
        last_bit = evt.valid && !waiting && (cnt == CNT_W'(WORD_W - 1));
        match    = !flt_en || (full[8] == flt_bits[0] && full[9] == flt_bits[1]);
        accept   = last_bit && match;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            cnt     <= '0;
            waiting <= 1'b0;
            hold    <= '0;
            ready   <= 1'b0;
        end else begin
            if (evt.abort) begin
                waiting <= 1'b1;
                cnt     <= '0;
            end else if (evt.gap) begin
                waiting <= 1'b0;
                cnt     <= '0;
            end else if (evt.valid && !waiting) begin
                if (cnt == CNT_W'(WORD_W - 1)) begin
                    cnt <= '0;
                end else begin
                    shreg[cnt] <= evt.value;
                    cnt        <= cnt + 1'b1;
                end
            end
            if (accept) hold <= full;
            if (accept) ready <= 1'b1;
            else if (rd_en && half_sel) ready <= 1'b0;
        end
    end

    AST_READY_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        accept |=> ready); // R9
    AST_READY_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ready && rd_en && half_sel && !accept) |=> !ready); // R9
    AST_HOLD_STILL: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(hold)); // R6
    AST_FILTER_BITS: assert property (@(posedge clk) disable iff (rst)
        (accept && flt_en) |=> (hold[8] == $past(flt_bits[0]) && hold[9] == $past(flt_bits[1]))); // R6

endmodule

// File: rtl/a429_rx.sv
module a429_rx
    import a429_rx_pkg::*;
#(
    parameter int DIV_FAST = 10,
    parameter int DIV_SLOW = 80,
    parameter int SPB      = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rate_sel,
    input  logic              line_one,
    input  logic              line_zero,
    input  logic              test_en,
    input  logic              tx_one,
    input  logic              tx_zero,
    input  logic              flt_en,
    input  logic [1:0]        flt_bits,
    input  logic              half_sel,
    input  logic              rd_en,
    output logic              ready,
    output logic [HALF_W-1:0] data_out
);
    logic              tick;
    lvl_e              lvl;
    bit_evt_t          evt;
    logic [WORD_W-1:0] hold;

    always_comb begin
        lvl = test_en ? decode_level(tx_one, tx_zero) : decode_level(line_one, line_zero);
    end

    a429_rx_tick #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_tick (
        .clk(clk), .rst(rst), .rate_sel(rate_sel), .tick(tick)
    );

    a429_rx_bit #(.SPB(SPB)) u_bit (
        .clk(clk), .rst(rst), .tick(tick), .lvl(lvl), .evt(evt)
    );

    a429_rx_frame u_frame (
        .clk(clk), .rst(rst), .evt(evt), .flt_en(flt_en), .flt_bits(flt_bits),
        .rd_en(rd_en), .half_sel(half_sel), .ready(ready), .hold(hold)
    );

    always_comb begin
        data_out = half_sel ? pack_second(hold) : pack_first(hold);
    end

endmodule

// File: tb/test_a429_rx.sv
module test_a429_rx;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rate_sel = 1'b0;
    logic        line_one = 1'b0;
    logic        line_zero = 1'b0;
    logic        test_en = 1'b0;
    logic        tx_one = 1'b0;
    logic        tx_zero = 1'b0;
    logic        flt_en = 1'b0;
    logic [1:0]  flt_bits = 2'b00;
    logic        half_sel = 1'b0;
    logic        rd_en = 1'b0;
    logic        ready;
    logic [15:0] data_out;

    int  checks = 0;
    int  fails = 0;
    bit  use_tx = 1'b0;

    always #10 clk = ~clk;

    a429_rx i_a429_rx (
        .clk(clk), .rst(rst), .rate_sel(rate_sel), .line_one(line_one),
        .line_zero(line_zero), .test_en(test_en), .tx_one(tx_one), .tx_zero(tx_zero),
        .flt_en(flt_en), .flt_bits(flt_bits), .half_sel(half_sel), .rd_en(rd_en),
        .ready(ready), .data_out(data_out)
    );

    function automatic logic [15:0] exp_first(input logic [31:0] w);
        logic [15:0] r;
        r[15] = w[12]; r[14] = w[11]; r[13] = w[10]; r[12] = w[9]; r[11] = w[8];
        r[10] = w[30]; r[9] = w[29]; r[8] = w[31];
        for (int k = 0; k < 8; k++) r[7-k] = w[k];
        return r;
    endfunction

    function automatic logic [15:0] exp_second(input logic [31:0] w);
        logic [15:0] r;
        for (int k = 0; k < 16; k++) r[k] = w[13+k];
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put_level(input bit hi, input bit lo, input int n);
        if (use_tx) begin tx_one = hi; tx_zero = lo; end
        else begin line_one = hi; line_zero = lo; end
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input bit v, input int div);
        put_level(v, !v, 5 * div);
        put_level(1'b0, 1'b0, 5 * div);
    endtask

    task automatic send_word(input logic [31:0] w, input int div);
        for (int i = 0; i < 32; i++) send_bit(w[i], div);
        put_level(1'b0, 1'b0, 40 * div);
    endtask

    task automatic read_half(input bit sel, output logic [15:0] v);
        half_sel = sel;
        #2;
        v = data_out;
    endtask

    task automatic check_word(input string req, input logic [31:0] w);
        logic [15:0] v;
        read_half(1'b0, v);
        check(req, {16'h0, v}, {16'h0, exp_first(w)});
        read_half(1'b1, v);
        check(req, {16'h0, v}, {16'h0, exp_second(w)});
    endtask

    task automatic ack();
        half_sel = 1'b1;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        half_sel = 1'b0;
        @(negedge clk);
    endtask

    localparam logic [31:0] W1  = 32'hA5C3_1E87;
    localparam logic [31:0] W2  = 32'h1234_5678;
    localparam logic [31:0] W3  = 32'hFEDC_BA98;
    localparam logic [31:0] W4  = 32'h6B2D_0391;
    localparam logic [31:0] W5  = W4 ^ 32'h0000_0100;
    localparam logic [31:0] W6  = 32'h0F0F_F0F0;
    localparam logic [31:0] W8  = 32'h8000_0001;
    localparam logic [31:0] W9  = 32'h3C96_69C3;
    localparam logic [31:0] W11 = 32'h55AA_33CC;

    task automatic t_reset();
        check("R12 ready", {31'h0, ready}, 32'h0);
        check_word("R12 data", 32'h0);
    endtask

    task automatic t_basic();
        send_word(W1, 10);
        check("R1 R2 ready", {31'h0, ready}, 32'h1);
        check_word("R8 R1 mapping", W1);
    endtask

    task automatic t_read();
        half_sel = 1'b0;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
        check("R9 first-half read keeps ready", {31'h0, ready}, 32'h1);
        ack();
        check("R9 second-half read clears", {31'h0, ready}, 32'h0);
    endtask

    task automatic t_overwrite();
        send_word(W2, 10);
        send_word(W3, 10);
        check("R10 ready", {31'h0, ready}, 32'h1);
        check_word("R10 overwrite", W3);
        ack();
    endtask

    task automatic t_filter();
        flt_en = 1'b1;
        flt_bits = {W4[9], W4[8]};
        send_word(W4, 10);
        check("R6 match accepted", {31'h0, ready}, 32'h1);
        check_word("R6 match data", W4);
        ack();
        send_word(W5, 10);
        check("R6 mismatch rejected", {31'h0, ready}, 32'h0);
        check_word("R6 data unchanged", W4);
        flt_en = 1'b0;
        send_word(W5, 10);
        check("R7 filter off accepted", {31'h0, ready}, 32'h1);
        check_word("R7 data", W5);
        ack();
    endtask

    task automatic t_invalid();
        for (int i = 0; i < 32; i++) begin
            if (i == 12) begin
                put_level(1'b1, 1'b1, 50);
                put_level(1'b0, 1'b0, 50);
            end else begin
                send_bit(W6[i], 10);
            end
        end
        put_level(1'b0, 1'b0, 400);
        check("R4 illegal level discards", {31'h0, ready}, 32'h0);
        check_word("R4 data unchanged", W5);
        send_word(W6, 10);
        check("R4 next word accepted", {31'h0, ready}, 32'h1);
        check_word("R4 next word data", W6);
        ack();
    endtask

    task automatic t_gap();
        for (int i = 0; i < 10; i++) send_bit(W2[i], 10);
        put_level(1'b0, 1'b0, 300);
        send_word(W8, 10);
        check("R5 ready after restart", {31'h0, ready}, 32'h1);
        check_word("R5 restart data", W8);
        ack();
    endtask

    task automatic t_rate();
        rate_sel = 1'b1;
        put_level(1'b0, 1'b0, 1200);
        send_word(W9, 80);
        check("R3 slow rate accepted", {31'h0, ready}, 32'h1);
        check_word("R3 slow data", W9);
        ack();
        send_word(W1, 10);
        put_level(1'b0, 1'b0, 1200);
        check("R3 wrong rate rejected", {31'h0, ready}, 32'h0);
        rate_sel = 1'b0;
        put_level(1'b0, 1'b0, 200);
    endtask

    task automatic t_selftest();
        line_one = 1'b1;
        line_zero = 1'b1;
        test_en = 1'b1;
        use_tx = 1'b1;
        put_level(1'b0, 1'b0, 200);
        send_word(W11, 10);
        check("R11 loopback accepted", {31'h0, ready}, 32'h1);
        check_word("R11 loopback data", W11);
        ack();
        use_tx = 1'b0;
        test_en = 1'b0;
        line_one = 1'b0;
        line_zero = 1'b0;
        put_level(1'b0, 1'b0, 200);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        t_basic();
        t_read();
        t_overwrite();
        t_filter();
        t_invalid();
        t_gap();
        t_rate();
        t_selftest();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule